// File: doc/BRIEF.md
# Lockable Authentication Register Bank

This block is the register file of a single-wire authentication slave. It holds a control register, a status register and two four-byte secret sets. After the asynchronous reset is released, and again after a soft reset, it copies its configuration from a one-time-programmable byte. That byte supplies the device address, the two secret lock bits and the default settings for the interrupt and auto-sleep enables. A host reaches the bank through a simple read/write port. The bus decoder and the OTP controller report events on dedicated pulse inputs.

Each lock bit blocks access to one secret set. A locked read returns zero and a locked write is dropped, and in both cases an error flag is raised. Bus faults, protection violations and accesses made while the OTP is busy set sticky flags. These flags clear when the status register is read. They are combined with their enables into a single interrupt line. An inactivity timer, built from a prescaler and a tick counter, requests sleep when auto-sleep is on. Writing the soft reset bit reloads the configuration and then requests a one-cycle break pulse toward the host.

Top module: `auth_regs`

## Requirements
- R1: In the first clock after rst_ni is released, the config byte otp_cfg_i is loaded. Bits [7:6] become the device address, shown on dev_addr_o and at status[7:6]. Bits [1:0] become the lock bits at status[5:4]. Bit 3 becomes the global interrupt enable at ctrl[2]. Bit 2 becomes the auto-sleep enable at ctrl[1]. Bits [5:4] read back at ctrl[5:4]. The control register is at address 0 and the status register at address 1.
- R2: ctrl[3] is the OTP-busy interrupt enable. It reads 1 when both loaded lock bits are 0 and 0 otherwise, and only a reload changes it. Host writes to it are ignored.
- R3: Secret set A occupies addresses 4..7 and is locked by lock bit 1. Secret set B occupies addresses 8..11 and is locked by lock bit 0. A read of a locked byte returns 0x00 and sets the bus error flag. A write to a locked byte leaves the stored value unchanged and sets the access error flag.
- R4: An unlocked secret byte reads back the last value written to it. Soft reset does not clear secret contents.
- R5: The bus error flag (status[1]) is set by any bit of bus_err_evt_i or by a locked secret read.
- R6: The access error flag (status[2]) is set by otp_wr_req_i while any lock bit is 1, or by test_acc_i while test_mode_i is 0. Neither input sets the flag in any other case.
- R7: The OTP-busy flag (status[0]) is set by any host read or write made while otp_busy_i is 1.
- R8: A status read returns the current flags and clears them at that clock edge. A flag whose set event arrives in the same cycle stays set.
- R9: irq_o = (global enable AND (bus error OR access error)) OR (OTP-busy enable AND OTP-busy flag).
- R10: With auto-sleep on, sleep_o rises exactly PRESC*TICKS clocks after the last bus_act_i edge. A bus_act_i pulse clears sleep_o and restarts the count.
- R11: With auto-sleep off, sleep_o stays low however long the bus is idle. It rises only on sleep_cmd_i.
- R12: Writing 1 to ctrl[0] triggers a reload at the next edge. The reload clears the flags, the timer and sleep_o, and takes the configuration from otp_cfg_i again. break_o is high for exactly the one cycle after that reload edge, and ctrl[0] reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| otp_cfg_i | input | 8 | Configuration byte from OTP |
| otp_busy_i | input | 1 | OTP write still in progress |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| bus_err_evt_i | input | BUS_EV_W | Bus fault event pulses |
| otp_wr_req_i | input | 1 | Host attempts an OTP write |
| test_acc_i | input | 1 | Host touches test/trim space |
| test_mode_i | input | 1 | Test mode active |
| bus_act_i | input | 1 | Bus activity pulse |
| sleep_cmd_i | input | 1 | Explicit sleep command |
| irq_o | output | 1 | Interrupt to host |
| sleep_o | output | 1 | Sleep request |
| break_o | output | 1 | Break pulse request |
| dev_addr_o | output | 2 | Device address bits |

## Verification
A status read and a bus fault event can fall in the same cycle. In that case the read-to-clear and the flag set compete for the same bit. The bench raises a bus_err_evt_i pulse on the very cycle it strobes the status read. It expects the returned byte to show the flag still clear, and the next status read to show the flag set. Locked and unlocked secret traffic, driven at random, is compared against a bench model of contents and lock state. The error flags that this traffic should have raised are compared at the end of each round.

// File: rtl/auth_regs_pkg.sv
package auth_regs_pkg;
  localparam int DATA_W = 8;
  // config byte fields
  localparam int CFG_GIE  = 3;
  localparam int CFG_ASLP = 2;
  // control register bits
  localparam int CTRL_SRST  = 0;
  localparam int CTRL_ASLP  = 1;
  localparam int CTRL_GIE   = 2;
  localparam int CTRL_WIPIE = 3;

  typedef struct packed {
    logic acc;
    logic bus;
    logic wip;
  } flags_t;
endpackage

// File: rtl/ar_secret_bank.sv
module ar_secret_bank #(
  parameter int ADDR_W    = 4,
  parameter int SEC_BASE  = 4,
  parameter int NUM_SETS  = 2,
  parameter int SET_BYTES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  input  logic [NUM_SETS-1:0] lock_i,
  output logic [7:0]          rdata_o,
  output logic                hit_o,
  output logic                lock_rd_o,
  output logic                lock_wr_o
);
  localparam int BYTE_W = (SET_BYTES > 1) ? $clog2(SET_BYTES) : 1;

  logic [NUM_SETS-1:0]             sel;
  logic [NUM_SETS-1:0]             blk;
  logic [BYTE_W-1:0]               bidx [NUM_SETS];
  logic [SET_BYTES-1:0][7:0]       mem_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    localparam int LO = SEC_BASE + s * SET_BYTES;
    localparam int HI = LO + SET_BYTES;

    always_comb begin
      sel[s]  = (32'(addr_i) >= LO) && (32'(addr_i) < HI);
      bidx[s] = BYTE_W'(32'(addr_i) - LO);
      // sets are locked in reverse order of the lock vector
      blk[s]  = lock_i[NUM_SETS-1-s];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[s] <= '0;
      else if (wr_i && sel[s] && !blk[s]) mem_q[s][bidx[s]] <= wdata_i;
    end

    assert_locked_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && sel[s] && blk[s]) |=> $stable(mem_q[s]));
  end

  always_comb begin
    rdata_o   = '0;
    lock_rd_o = 1'b0;
    lock_wr_o = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (sel[s]) begin
        if (!blk[s]) rdata_o = mem_q[s][bidx[s]];
        lock_rd_o = rd_i && blk[s];
        lock_wr_o = wr_i && blk[s];
      end
    end
  end

  assign hit_o = |sel;
endmodule

// File: rtl/ar_flags.sv
module ar_flags
  import auth_regs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   rd_clr_i,
  input  logic   set_wip_i,
  input  logic   set_bus_i,
  input  logic   set_acc_i,
  input  logic   gie_i,
  input  logic   wip_ie_i,
  output flags_t flags_o,
  output logic   irq_o
);
  flags_t flags_q;
  logic   clr;

  assign clr = clr_i | rd_clr_i;

  // a set in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else begin
      flags_q.wip <= set_wip_i | (flags_q.wip & ~clr);
      flags_q.bus <= set_bus_i | (flags_q.bus & ~clr);
      flags_q.acc <= set_acc_i | (flags_q.acc & ~clr);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = (gie_i & (flags_q.bus | flags_q.acc)) | (wip_ie_i & flags_q.wip);

  assert_bus_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_bus_i |=> flags_o.bus);
  assert_acc_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_acc_i |=> flags_o.acc);
  assert_rd_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !set_bus_i) |=> !flags_o.bus);
endmodule

// File: rtl/ar_sleep_timer.sv
module ar_sleep_timer #(
  parameter int PRESC = 1_000_000,
  parameter int TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic act_i,
  input  logic cmd_i,
  output logic sleep_o
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [PW-1:0] pcnt_q;
  logic [TW-1:0] tcnt_q;
  logic          sleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0; tcnt_q <= '0; sleep_q <= 1'b0;
    end else if (clr_i) begin
      pcnt_q <= '0; tcnt_q <= '0; sleep_q <= 1'b0;
    end else if (cmd_i) begin
      pcnt_q <= '0; tcnt_q <= '0; sleep_q <= 1'b1;
    end else if (act_i) begin
      pcnt_q <= '0; tcnt_q <= '0; sleep_q <= 1'b0;
    end else if (!en_i || sleep_q) begin
      pcnt_q <= '0; tcnt_q <= '0;
    end else if (pcnt_q == PW'(PRESC - 1)) begin
      pcnt_q <= '0;
      if (tcnt_q == TW'(TICKS - 1)) begin
        tcnt_q  <= '0;
        sleep_q <= 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign sleep_o = sleep_q;

  assert_act_wakes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !cmd_i) |=> !sleep_o);
  assert_auto_needs_en_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sleep_o) && !$past(cmd_i)) |-> $past(en_i));
endmodule

// File: rtl/auth_regs.sv
module auth_regs
  import auth_regs_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int SEC_BASE  = 4,
  parameter int NUM_SETS  = 2,
  parameter int SET_BYTES = 4,
  parameter int BUS_EV_W  = 4,
  parameter int PRESC     = 1_000_000,
  parameter int TICKS     = 50
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          otp_cfg_i,
  input  logic                otp_busy_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic [BUS_EV_W-1:0] bus_err_evt_i,
  input  logic                otp_wr_req_i,
  input  logic                test_acc_i,
  input  logic                test_mode_i,
  input  logic                bus_act_i,
  input  logic                sleep_cmd_i,
  output logic                irq_o,
  output logic                sleep_o,
  output logic                break_o,
  output logic [1:0]          dev_addr_o
);
  localparam int LOCK_W = NUM_SETS;
  localparam logic [7:0] CFG_SAFE = 8'(2**LOCK_W - 1);

  logic              load_q, srst_q, brk_q, reload;
  logic [7:0]        cfg_q;
  logic              gie_q, aslp_q, wip_ie_q;
  logic [LOCK_W-1:0] lock;
  logic              ctrl_sel, stat_sel, ctrl_wr;
  logic [7:0]        sec_rdata;
  logic              sec_hit, lock_rd, lock_wr;
  flags_t            flags;
  logic              set_wip, set_bus, set_acc;

  assign reload   = load_q | srst_q;
  assign ctrl_sel = (32'(addr_i) == CTRL_ADDR);
  assign stat_sel = (32'(addr_i) == STAT_ADDR);
  assign ctrl_wr  = wr_i & ctrl_sel;
  assign lock     = cfg_q[LOCK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= 1'b1;
      srst_q   <= 1'b0;
      brk_q    <= 1'b0;
      cfg_q    <= CFG_SAFE;
      gie_q    <= 1'b0;
      aslp_q   <= 1'b0;
      wip_ie_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      brk_q  <= srst_q;
      if (reload) begin
        srst_q   <= 1'b0;
        cfg_q    <= otp_cfg_i;
        gie_q    <= otp_cfg_i[CFG_GIE];
        aslp_q   <= otp_cfg_i[CFG_ASLP];
        wip_ie_q <= ~|otp_cfg_i[LOCK_W-1:0];
      end else if (ctrl_wr) begin
        srst_q <= wdata_i[CTRL_SRST];
        gie_q  <= wdata_i[CTRL_GIE];
        aslp_q <= wdata_i[CTRL_ASLP];
      end
    end
  end

  ar_secret_bank #(
    .ADDR_W(ADDR_W), .SEC_BASE(SEC_BASE), .NUM_SETS(NUM_SETS), .SET_BYTES(SET_BYTES)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .lock_i(lock), .rdata_o(sec_rdata), .hit_o(sec_hit),
    .lock_rd_o(lock_rd), .lock_wr_o(lock_wr)
  );

  assign set_wip = (rd_i | wr_i) & otp_busy_i;
  assign set_bus = (|bus_err_evt_i) | lock_rd;
  assign set_acc = (otp_wr_req_i & (|lock)) | (test_acc_i & ~test_mode_i) | lock_wr;

  ar_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(srst_q), .rd_clr_i(rd_i & stat_sel),
    .set_wip_i(set_wip), .set_bus_i(set_bus), .set_acc_i(set_acc),
    .gie_i(gie_q), .wip_ie_i(wip_ie_q), .flags_o(flags), .irq_o(irq_o)
  );

  ar_sleep_timer #(.PRESC(PRESC), .TICKS(TICKS)) u_sleep (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(srst_q), .en_i(aslp_q),
    .act_i(bus_act_i), .cmd_i(sleep_cmd_i), .sleep_o(sleep_o)
  );

  always_comb begin
    if (ctrl_sel)
      rdata_o = {2'b00, cfg_q[5:4], wip_ie_q, gie_q, aslp_q, srst_q};
    else if (stat_sel)
      rdata_o = {cfg_q[7:6], cfg_q[1:0], 1'b0, flags.acc, flags.bus, flags.wip};
    else if (sec_hit)
      rdata_o = sec_rdata;
    else
      rdata_o = '0;
  end

  assign break_o    = brk_q;
  assign dev_addr_o = cfg_q[7:6];

  assert_wip_ie_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload |=> $stable(wip_ie_q));
  assert_break_follows_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> break_o);
  assert_break_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |=> !break_o);
  assert_srst_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !sleep_o);
endmodule

// File: tb/sim_auth_regs.sv
module sim_auth_regs;
  localparam int PRESC = 4;
  localparam int TICKS = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] otp_cfg_i = 8'h00;
  logic       otp_busy_i = 1'b0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] bus_err_evt_i = '0;
  logic       otp_wr_req_i = 1'b0, test_acc_i = 1'b0, test_mode_i = 1'b0;
  logic       bus_act_i = 1'b0, sleep_cmd_i = 1'b0;
  logic       irq_o, sleep_o, break_o;
  logic [1:0] dev_addr_o;

  auth_regs #(.PRESC(PRESC), .TICKS(TICKS)) u0 (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] smem [12];
  logic [7:0] cfg_m;
  logic       gie_m;

  function automatic logic [7:0] exp_ctrl(logic [7:0] c, logic g, logic a);
    return {2'b00, c[5:4], ~|c[1:0], g, a, 1'b0};
  endfunction
  function automatic logic [7:0] exp_stat(logic [7:0] c, logic a, logic b, logic w);
    return {c[7:6], c[1:0], 1'b0, a, b, w};
  endfunction
  function automatic bit is_locked(logic [7:0] c, int a);
    if (a >= 4 && a < 8) return c[1];
    return c[0];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk_i); wr_i = 1; addr_i = 4'(a); wdata_i = d;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk_i); rd_i = 1; addr_i = 4'(a);
    #1 d = rdata_o;
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic soft_rst(logic [7:0] c);
    otp_cfg_i = c;
    wr(0, 8'h01);
    @(negedge clk_i);
    cfg_m = c; gie_m = c[3];
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    otp_cfg_i = 8'h98; // dev 2, spare 01, gie 1, auto-sleep 0, lock 00
    #25;
    chk("R12 reset break", {7'b0, break_o}, 8'h00);
    chk("R9 reset irq", {7'b0, irq_o}, 8'h00);
    chk("R10 reset sleep", {7'b0, sleep_o}, 8'h00);
    rst_ni = 1;
    cfg_m = 8'h98; gie_m = 1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R1 dev addr", {6'b0, dev_addr_o}, 8'h02);
    rd(0, d); chk("R1 ctrl", d, exp_ctrl(cfg_m, 1, 0));
    rd(1, d); chk("R1 status", d, exp_stat(cfg_m, 0, 0, 0));

    // R2: writes to the busy-interrupt enable ignored
    wr(0, 8'h04);
    rd(0, d); chk("R2 wip_ie write ignored", d, exp_ctrl(cfg_m, 1, 0));

    // R4 unlocked secrets
    for (int a = 4; a < 12; a++) begin smem[a] = 8'($urandom); wr(a, smem[a]); end
    for (int a = 4; a < 12; a++) begin rd(a, d); chk("R4 readback", d, smem[a]); end
    rd(1, d); chk("R4 no error flags", d, exp_stat(cfg_m, 0, 0, 0));

    // R5 each bus event bit, R8 clear on read, R9 irq with gie
    for (int b = 0; b < 4; b++) begin
      @(negedge clk_i); bus_err_evt_i = 4'(1 << b);
      @(negedge clk_i); bus_err_evt_i = '0;
      chk("R9 irq bus err", {7'b0, irq_o}, 8'h01);
      rd(1, d); chk("R5 bus event", d, exp_stat(cfg_m, 0, 1, 0));
      rd(1, d); chk("R8 cleared", d, exp_stat(cfg_m, 0, 0, 0));
    end

    // R6
    @(negedge clk_i); otp_wr_req_i = 1; @(negedge clk_i); otp_wr_req_i = 0;
    rd(1, d); chk("R6 otp write unlocked no flag", d, exp_stat(cfg_m, 0, 0, 0));
    @(negedge clk_i); test_acc_i = 1; test_mode_i = 1; @(negedge clk_i); test_acc_i = 0;
    rd(1, d); chk("R6 test access in test mode", d, exp_stat(cfg_m, 0, 0, 0));
    test_mode_i = 0;
    @(negedge clk_i); test_acc_i = 1; @(negedge clk_i); test_acc_i = 0;
    rd(1, d); chk("R6 test access outside test mode", d, exp_stat(cfg_m, 1, 0, 0));

    // R7 / R9 busy flag with gie off
    wr(0, 8'h00); gie_m = 0;
    otp_busy_i = 1; rd(0, d); otp_busy_i = 0;
    chk("R9 irq from busy flag", {7'b0, irq_o}, 8'h01);
    rd(1, d); chk("R7 busy flag", d, exp_stat(cfg_m, 0, 0, 1));
    @(negedge clk_i); bus_err_evt_i = 4'h1; @(negedge clk_i); bus_err_evt_i = '0;
    chk("R9 irq masked by gie", {7'b0, irq_o}, 8'h00);
    rd(1, d);

    // R8 set and clear in the same cycle
    @(negedge clk_i); rd_i = 1; addr_i = 4'd1; bus_err_evt_i = 4'h4;
    #1 d = rdata_o;
    @(negedge clk_i); rd_i = 0; bus_err_evt_i = '0;
    chk("R8 read during set returns old", d, exp_stat(cfg_m, 0, 0, 0));
    rd(1, d); chk("R8 set wins over clear", d, exp_stat(cfg_m, 0, 1, 0));

    // R12 soft reset sequence, new config locks set A
    @(negedge clk_i); bus_err_evt_i = 4'h2; @(negedge clk_i); bus_err_evt_i = '0;
    otp_cfg_i = 8'h42;
    wr(0, 8'h05);
    chk("R12 no break before reload", {7'b0, break_o}, 8'h00);
    @(negedge clk_i);
    chk("R12 break high", {7'b0, break_o}, 8'h01);
    chk("R12 dev reloaded", {6'b0, dev_addr_o}, 8'h01);
    @(negedge clk_i);
    chk("R12 break single cycle", {7'b0, break_o}, 8'h00);
    cfg_m = 8'h42; gie_m = 0;
    rd(0, d); chk("R12 R2 ctrl after reload", d, exp_ctrl(cfg_m, 0, 0));
    rd(1, d); chk("R12 flags cleared", d, exp_stat(cfg_m, 0, 0, 0));

    // R3 locked set A, set B open
    rd(5, d); chk("R3 locked read zero", d, 8'h00);
    rd(1, d); chk("R3 locked read bus flag", d, exp_stat(cfg_m, 0, 1, 0));
    wr(6, ~smem[6]);
    rd(1, d); chk("R3 locked write acc flag", d, exp_stat(cfg_m, 1, 0, 0));
    rd(9, d); chk("R3 set B open", d, smem[9]);
    @(negedge clk_i); otp_wr_req_i = 1; @(negedge clk_i); otp_wr_req_i = 0;
    rd(1, d); chk("R6 otp write while locked", d, exp_stat(cfg_m, 1, 0, 0));
    otp_busy_i = 1; rd(0, d); otp_busy_i = 0;
    chk("R2 busy irq disabled by lock", {7'b0, irq_o}, 8'h00);
    rd(1, d);
    soft_rst(8'h00);
    rd(6, d); chk("R3 locked write ignored", d, smem[6]);
    rd(1, d);

    // random rounds against the model
    for (int r = 0; r < 8; r++) begin
      logic [7:0] c;
      bit eb, ea;
      c = {2'($urandom), 2'b00, 1'($urandom), 1'b0, 2'($urandom)};
      soft_rst(c);
      eb = 0; ea = 0;
      for (int j = 0; j < 12; j++) begin
        int a;
        a = 4 + int'($urandom % 8);
        if ($urandom % 2) begin
          logic [7:0] v;
          v = 8'($urandom);
          wr(a, v);
          if (is_locked(c, a)) ea = 1; else smem[a] = v;
        end else begin
          rd(a, d);
          if (is_locked(c, a)) begin eb = 1; chk("R3 random locked read", d, 8'h00); end
          else chk("R4 random read", d, smem[a]);
        end
      end
      rd(1, d); chk("R3 random flags", d, exp_stat(c, ea, eb, 0));
    end

    // R10 auto-sleep timing
    soft_rst(8'h04);
    bus_act_i = 1; @(negedge clk_i); bus_act_i = 0;
    repeat (PRESC * TICKS - 1) @(negedge clk_i);
    chk("R10 not asleep early", {7'b0, sleep_o}, 8'h00);
    @(negedge clk_i);
    chk("R10 asleep on time", {7'b0, sleep_o}, 8'h01);
    bus_act_i = 1; @(negedge clk_i); bus_act_i = 0;
    chk("R10 activity wakes", {7'b0, sleep_o}, 8'h00);

    // R11 auto-sleep off
    wr(0, 8'h00);
    repeat (PRESC * TICKS * 3) @(negedge clk_i);
    chk("R11 no auto sleep", {7'b0, sleep_o}, 8'h00);
    sleep_cmd_i = 1; @(negedge clk_i); sleep_cmd_i = 0;
    chk("R11 sleep on command", {7'b0, sleep_o}, 8'h01);
    bus_act_i = 1; @(negedge clk_i); bus_act_i = 0;
    chk("R11 wake after command", {7'b0, sleep_o}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule